// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit offset into a 20-bit linear memory address using real-mode segmentation. It keeps four 16-bit segment registers (code, data, extra and stack), which are loaded through a simple write port. The address is the chosen segment value shifted left by four bits plus the offset, truncated to 20 bits. This gives a 1 MB address space in which any one segment spans at most 64 KB.

Each request carries an access kind, the base register used to form the offset and an optional segment override. A fixed rule set uses these to pick the segment register. One cycle after the request, the block presents the registered address together with the identity of the segment it used. The address pipeline of a simple processor core uses the block to serve instruction fetch, stack, operand and string-destination accesses.

Top module: `seg_addr_gen`

## Requirements
- R1: One clock after a cycle with `req_valid` high, `out_addr` equals (16 × selected segment value + `req_offset`) and `out_seg` gives the selected segment. Segment codes are 0 = extra, 1 = code, 2 = stack, 3 = data.
- R2: When the sum exceeds 0xFFFFF, the address wraps modulo 2^20. For example, segment 0xFFFF with offset 0x0010 gives 0x00000.
- R3: An access of kind 0 (instruction fetch) uses the code segment (1), whatever `req_ovr_en`, `req_ovr_seg` and `req_base` hold.
- R4: An access of kind 1 (stack push/pop) uses the stack segment (2), whatever the override and base inputs hold.
- R5: An access of kind 2 (memory operand) with `req_ovr_en` low uses the stack segment when `req_base` is 4 (stack pointer) or 5 (frame pointer). With any other base code it uses the data segment (3).
- R6: An access of kind 2 with `req_ovr_en` high uses the segment coded on `req_ovr_seg`, regardless of `req_base`.
- R7: An access of kind 3 (string destination) uses the extra segment (0), whatever the override and base inputs hold.
- R8: `out_valid` equals `req_valid` of the previous cycle. In a cycle after one with `req_valid` low, `out_addr` and `out_seg` keep their values.
- R9: A write with `wr_en` high loads `wr_data` into the segment coded on `wr_sel`, and the new value is first used by a request in the following cycle. A request in the same cycle as the write uses the old value.
- R10: Synchronous active-low reset clears all segment registers, `out_valid`, `out_addr` and `out_seg` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 2 | Segment code to write |
| wr_data | input | 16 | Value to write |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 2 | Access kind: 0 fetch, 1 stack, 2 operand, 3 string destination |
| req_base | input | 3 | Base register code of the operand (4 stack pointer, 5 frame pointer) |
| req_ovr_en | input | 1 | Segment override present |
| req_ovr_seg | input | 2 | Override segment code |
| req_offset | input | 16 | Offset within the segment |
| out_valid | output | 1 | Registered address valid |
| out_addr | output | 20 | Registered linear address |
| out_seg | output | 2 | Code of the segment used |

## Verification
The hardest case to reach from the ports is a segment write and a request that reads the same register in the same clock. In that case the old value must win. The stimulus sets up this collision on purpose. It writes the extra segment while it issues a string-destination request, and it writes the data segment while it issues an operand request. It then issues a follow-up request to show that the new value took effect. Wrap-around needs a segment near the top of the space, so a fixed segment of 0xFFFF is loaded before the directed wrap cases run. A seeded random phase then mixes all kinds, base codes, overrides and writes.

// File: rtl/seg_addr_pkg.sv
// Shared codes for the segmented address generator.
// Assumes four segment registers addressed by a 2-bit code.
package seg_addr_pkg;
    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_id_e;

    typedef enum logic [1:0] {
        ACC_FETCH   = 2'd0,
        ACC_STACK   = 2'd1,
        ACC_DATA    = 2'd2,
        ACC_STR_DST = 2'd3
    } acc_kind_e;

    localparam int NUM_SEGS = 4;
    localparam int SEG_IDX_W = $clog2(NUM_SEGS);
endpackage

// File: rtl/seg_regfile.sv
// Segment register file: N_SEG registers of SEG_W bits with one write port.
// Assumes writes land on the clock edge, so readers see new data next cycle.
module seg_regfile #(
    parameter int SEG_W = 16,
    parameter int N_SEG = 4,
    localparam int IDX_W = $clog2(N_SEG)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_sel,
    input  logic [SEG_W-1:0]            wr_data,
    output logic [N_SEG-1:0][SEG_W-1:0] seg_vals
);
    for (genvar i = 0; i < N_SEG; i++) begin : g_seg
        // Load one segment register when it is addressed by the write port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_vals[i] <= '0;
            end else if (wr_en && (wr_sel == IDX_W'(i))) begin
                seg_vals[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/seg_select.sv
// Segment choice rules: fetch -> code, stack -> stack, string destination -> extra;
// operands take the override if present, else stack for stack/frame pointer bases,
// else data. Purely combinational.
module seg_select
    import seg_addr_pkg::*;
#(
    parameter int          BASE_W  = 3,
    parameter logic [BASE_W-1:0] SP_CODE = BASE_W'(4),
    parameter logic [BASE_W-1:0] BP_CODE = BASE_W'(5)
) (
    input  acc_kind_e          kind,
    input  logic [BASE_W-1:0]  base,
    input  logic               ovr_en,
    input  seg_id_e            ovr_seg,
    output seg_id_e            seg_id
);
    logic stack_base;

    // Flag bases that imply the stack segment.
    always_comb stack_base = (base == SP_CODE) || (base == BP_CODE);

    // Apply the rule set by access kind.
    always_comb begin
        unique case (kind)
            ACC_FETCH:   seg_id = SEG_CS;
            ACC_STACK:   seg_id = SEG_SS;
            ACC_STR_DST: seg_id = SEG_ES;
            default: begin
                if (ovr_en)          seg_id = ovr_seg;
                else if (stack_base) seg_id = SEG_SS;
                else                 seg_id = SEG_DS;
            end
        endcase
    end
endmodule

// File: rtl/addr_adder.sv
// Linear address adder: (segment << SHIFT) + offset, truncated to ADDR_W so
// results wrap at the top of the address space.
module addr_adder #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int ADDR_W = (SEG_W + SHIFT > OFF_W) ? SEG_W + SHIFT : OFF_W
) (
    input  logic [SEG_W-1:0]  seg_val,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] lin_addr
);
    logic [SEG_W+SHIFT-1:0] seg_shifted;

    // Scale the segment to a paragraph base.
    always_comb seg_shifted = {seg_val, {SHIFT{1'b0}}};

    // Add in the address width; the carry out is dropped.
    always_comb lin_addr = ADDR_W'(seg_shifted) + ADDR_W'(offset);
endmodule

// File: rtl/seg_addr_gen.sv
// Top: segment registers, rule-based segment choice, adder and output register.
// Assumes one request per cycle and a fixed one-cycle output latency.
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int BASE_W = 3,
    localparam int ADDR_W = (SEG_W + SHIFT > OFF_W) ? SEG_W + SHIFT : OFF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [SEG_W-1:0]     wr_data,
    input  logic                 req_valid,
    input  logic [1:0]           req_kind,
    input  logic [BASE_W-1:0]    req_base,
    input  logic                 req_ovr_en,
    input  logic [1:0]           req_ovr_seg,
    input  logic [OFF_W-1:0]     req_offset,
    output logic                 out_valid,
    output logic [ADDR_W-1:0]    out_addr,
    output logic [1:0]           out_seg
);
    logic [NUM_SEGS-1:0][SEG_W-1:0] seg_vals;
    seg_id_e                        pick;
    logic [SEG_W-1:0]               pick_val;
    logic [ADDR_W-1:0]              next_addr;

    seg_regfile #(.SEG_W(SEG_W), .N_SEG(NUM_SEGS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .seg_vals (seg_vals)
    );

    seg_select #(.BASE_W(BASE_W)) u_sel (
        .kind    (acc_kind_e'(req_kind)),
        .base    (req_base),
        .ovr_en  (req_ovr_en),
        .ovr_seg (seg_id_e'(req_ovr_seg)),
        .seg_id  (pick)
    );

    // Read the chosen segment value.
    always_comb pick_val = seg_vals[pick];

    addr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_add (
        .seg_val  (pick_val),
        .offset   (req_offset),
        .lin_addr (next_addr)
    );

    // Track the request strobe one cycle behind.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= req_valid;
    end

    // Capture address and segment code on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr <= '0;
            out_seg  <= '0;
        end else if (req_valid) begin
            out_addr <= next_addr;
            out_seg  <= pick;
        end
    end
endmodule

// File: rtl/seg_addr_chk.sv
// Checker for seg_addr_gen: segment choice rules and output timing.
module seg_addr_chk #(
    parameter int BASE_W = 3,
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [BASE_W-1:0] req_base,
    input logic              req_ovr_en,
    input logic [1:0]        req_ovr_seg,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic [1:0]        out_seg
);
    AST_FETCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd0) |=> (out_seg == 2'd1)); // R3
    AST_STACK_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd1) |=> (out_seg == 2'd2)); // R4
    AST_FRAME_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2 && !req_ovr_en &&
         (req_base == BASE_W'(4) || req_base == BASE_W'(5))) |=> (out_seg == 2'd2)); // R5
    AST_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2 && req_ovr_en) |=> (out_seg == $past(req_ovr_seg))); // R6
    AST_STR_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |=> (out_seg == 2'd0)); // R7
    AST_VALID_ON: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R8
    AST_VALID_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(out_addr) && $stable(out_seg))); // R8
endmodule

bind seg_addr_gen seg_addr_chk #(.BASE_W(BASE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kind    (req_kind),
    .req_base    (req_base),
    .req_ovr_en  (req_ovr_en),
    .req_ovr_seg (req_ovr_seg),
    .out_valid   (out_valid),
    .out_addr    (out_addr),
    .out_seg     (out_seg)
);

// File: tb/sim_seg_addr_gen.sv
// Bench for seg_addr_gen with a behavioural reference model compared every clock.
module sim_seg_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [2:0]  req_base = '0;
    logic        req_ovr_en = 1'b0;
    logic [1:0]  req_ovr_seg = '0;
    logic [15:0] req_offset = '0;
    logic        out_valid;
    logic [19:0] out_addr;
    logic [1:0]  out_seg;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int ref_seg [4];
    int exp_valid = 0;
    int exp_addr = 0;
    int exp_seg = 0;

    always #10 clk = ~clk;

    seg_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .req_valid(req_valid), .req_kind(req_kind), .req_base(req_base),
        .req_ovr_en(req_ovr_en), .req_ovr_seg(req_ovr_seg), .req_offset(req_offset),
        .out_valid(out_valid), .out_addr(out_addr), .out_seg(out_seg)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int ref_pick(int k, int b, bit oe, int os);
        if (k == 0) return 1;
        if (k == 1) return 2;
        if (k == 3) return 0;
        if (oe) return os;
        if (b == 4 || b == 5) return 2;
        return 3;
    endfunction

    // Drive one cycle at the falling edge, advance the model, compare at the next falling edge.
    task automatic step(input string tag, input bit v, input int k, input int b,
                        input bit oe, input int os, input int off,
                        input bit we, input int ws, input int wd);
        int s;
        req_valid = v; req_kind = 2'(k); req_base = 3'(b);
        req_ovr_en = oe; req_ovr_seg = 2'(os); req_offset = 16'(off);
        wr_en = we; wr_sel = 2'(ws); wr_data = 16'(wd);
        exp_valid = v;
        if (v) begin
            s = ref_pick(k, b, oe, os);
            exp_seg = s;
            exp_addr = ((ref_seg[s] * 16) + off) % (1 << 20);
        end
        if (we) ref_seg[ws] = wd;
        @(posedge clk);
        @(negedge clk);
        chk(tag, "valid", int'(out_valid), exp_valid);
        chk(tag, "addr", int'(out_addr), exp_addr);
        chk(tag, "seg", int'(out_seg), exp_seg);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) ref_seg[i] = 0;
        repeat (3) @(negedge clk);
        chk("R10", "reset valid", int'(out_valid), 0);
        chk("R10", "reset addr", int'(out_addr), 0);
        chk("R10", "reset seg", int'(out_seg), 0);
        rst_n = 1'b1;
        // R10: registers cleared, so a fetch gives the bare offset
        step("R10", 1, 0, 0, 0, 0, 16'h1234, 0, 0, 0);
        // R9: load all four segments
        step("R9", 0, 0, 0, 0, 0, 0, 1, 1, 16'hF000);
        step("R9", 0, 0, 0, 0, 0, 0, 1, 3, 16'h1234);
        step("R9", 0, 0, 0, 0, 0, 0, 1, 2, 16'h2000);
        step("R9", 0, 0, 0, 0, 0, 0, 1, 0, 16'hFFFF);
        step("R1", 1, 0, 3, 0, 0, 16'hFFF0, 0, 0, 0);
        step("R3", 1, 0, 5, 1, 3, 16'h0004, 0, 0, 0);
        step("R4", 1, 1, 3, 1, 0, 16'h0100, 0, 0, 0);
        step("R5", 1, 2, 4, 0, 0, 16'h0010, 0, 0, 0);
        step("R5", 1, 2, 5, 0, 0, 16'h0020, 0, 0, 0);
        step("R5", 1, 2, 3, 0, 0, 16'h0030, 0, 0, 0);
        step("R5", 1, 2, 0, 0, 0, 16'hFFFF, 0, 0, 0);
        step("R6", 1, 2, 5, 1, 0, 16'h0040, 0, 0, 0);
        step("R6", 1, 2, 3, 1, 1, 16'h0050, 0, 0, 0);
        step("R6", 1, 2, 4, 1, 3, 16'h0060, 0, 0, 0);
        step("R7", 1, 3, 5, 1, 3, 16'h0008, 0, 0, 0);
        step("R2", 1, 3, 0, 0, 0, 16'h0010, 0, 0, 0);
        step("R2", 1, 3, 0, 0, 0, 16'hFFFF, 0, 0, 0);
        step("R8", 0, 2, 0, 1, 1, 16'hAAAA, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 0, 16'h5555, 0, 0, 0);
        // R9: write and request the same register in one cycle
        step("R9", 1, 3, 0, 0, 0, 16'h0002, 1, 0, 16'h0100);
        step("R9", 1, 3, 0, 0, 0, 16'h0002, 0, 0, 0);
        step("R9", 1, 2, 1, 0, 0, 16'h0003, 1, 3, 16'h4000);
        step("R9", 1, 2, 1, 0, 0, 16'h0003, 0, 0, 0);
        void'($urandom(7));
        for (int n = 0; n < 400; n++) begin
            step("R1", bit'($urandom_range(0, 3) != 0), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 7)), bit'($urandom_range(0, 1)),
                 int'($urandom_range(0, 3)), int'($urandom_range(0, 65535)),
                 bit'($urandom_range(0, 3) == 0), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 65535)));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule